// File: doc/BRIEF.md
# Packet Buffer Pointer Port

This block gives a host byte-level access to on-chip packet buffer memory through a small register window. The memory is split into 2048-byte pages. The host loads a 16-bit pointer. The low eleven bits of the pointer are a byte offset inside a page. Two upper flag bits control the access: one selects where the page number comes from, and the other turns on automatic stepping of the offset. Reads and writes at the four data-window addresses then reach the selected page at the pointer offset plus the lane position inside the window.

A host access may be one, two or four bytes wide. The block splits it into single-byte steps in ascending address order, one step per cycle. Each step sees the pointer as the steps before it left it. The buffer is a synchronous single-port byte RAM inside the block. When the flag bit is set, the page number comes from a receive-queue head input. When it is clear, the page number comes from a packet-number input.

Top module: `pktbuf_ptr_port`

## Requirements
- R1: After reset the pointer reads as 0x0000, `host_busy` is low and `host_rvalid` is low.
- R2: A byte write at address 6 replaces only pointer bits [7:0]. A byte write at address 7 replaces only bits [15:8].
- R3: A read at address 6 returns pointer bits [7:0] unmasked. A read at address 7 returns bits [15:8] ANDed with 0xF7, so pointer bit 11 always reads as 0.
- R4: A data-window byte at address 8+L (L = 0..3) reaches page offset (pointer[10:0] + L). A write stores the byte there, and a later read of that location returns it.
- R5: When pointer bit 15 is 1, the page index is `rx_head`. When it is 0, the page index is `pkt_num`.
- R6: When pointer bit 14 is 1, each data-window byte adds one to pointer[10:0] modulo 2048 and leaves bits [15:11] unchanged. When bit 14 is 0, data accesses leave the pointer unchanged.
- R7: `host_size` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The bytes are handled at addresses base, base+1, … (4-bit wrap), in that order. Each byte sees the pointer updates made by the earlier bytes, and byte i maps to `host_wdata`/`host_rdata` bits [8i+7:8i].
- R8: A request is accepted only while `host_busy` is low. For an n-byte access accepted at a clock edge, `host_rvalid` rises after the (n+1)-th following edge and stays high for exactly one cycle, and `host_busy` drops at that same edge. Requests raised while busy are ignored.
- R9: Bytes at addresses outside 6..11 are ignored on write, leaving the pointer and memory unchanged, and read as 0x00.
- R10: The lane addition wraps inside the page: offset 0x7FE with lane 3 reaches offset 0x001 of the same page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, sampled while not busy |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Byte address of the first byte |
| host_size | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| host_wdata | input | 32 | Write data, byte i in bits [8i+7:8i] |
| pkt_num | input | PAGE_W | Page index used when pointer bit 15 is 0 |
| rx_head | input | PAGE_W | Page index used when pointer bit 15 is 1 |
| host_busy | output | 1 | Access in progress |
| host_rvalid | output | 1 | One-cycle completion pulse; read data valid |
| host_rdata | output | 32 | Read data, byte i in bits [8i+7:8i] |

## Verification
When an n-byte access is accepted at a clock edge, its completion pulse and read data are due after exactly n+1 further edges. The bench drives and samples on falling edges. It counts falling edges from acceptance until the pulse and compares the count with n+1. Pointer and memory effects are checked only through later accesses, after the earlier access has completed. Read data is compared only for bytes whose memory location the reference model has already written.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
    localparam int OFF_W       = 11;
    localparam int PTR_W       = 16;
    localparam int LANES       = 4;
    localparam int BUS_W       = 8 * LANES;
    localparam int AUTOINC_BIT = 14;
    localparam int PAGESEL_BIT = 15;

    localparam logic [3:0] ADR_PTR_LO  = 4'd6;
    localparam logic [3:0] ADR_PTR_HI  = 4'd7;
    localparam logic [7:0] HI_RD_MASK  = 8'hF7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic             wr;
        logic [3:0]       base;
        logic [1:0]       last;
        logic [1:0]       idx;
        logic [BUS_W-1:0] wdata;
        logic [PTR_W-1:0] ptr;
        logic [BUS_W-1:0] rbuf;
        logic             pend;
        logic [1:0]       plane;
        logic             rvalid;
    } seq_state_t;

    function automatic logic [1:0] size_to_last(input logic [1:0] sz);
        case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/pbp_byte_ram.sv
module pbp_byte_ram #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen import pbp_pkg::*; #(
    parameter int PAGE_W = 1
) (
    input  logic [PTR_W-1:0]        ptr,
    input  logic [1:0]              lane,
    input  logic [PAGE_W-1:0]       pkt_num,
    input  logic [PAGE_W-1:0]       rx_head,
    output logic [PAGE_W+OFF_W-1:0] ram_addr,
    output logic [PTR_W-1:0]        ptr_next
);
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;

    // page source picked by the select flag
    assign page     = ptr[PAGESEL_BIT] ? rx_head : pkt_num;
    // lane addition wraps inside the page
    assign off      = ptr[OFF_W-1:0] + OFF_W'(lane);
    assign ram_addr = {page, off};
    // stepping touches only the offset field
    assign ptr_next = ptr[AUTOINC_BIT]
                    ? {ptr[PTR_W-1:OFF_W], ptr[OFF_W-1:0] + OFF_W'(1)}
                    : ptr;
endmodule

// File: rtl/pbp_rd_merge.sv
module pbp_rd_merge import pbp_pkg::*; (
    input  logic [BUS_W-1:0] rbuf,
    input  logic             pend,
    input  logic [1:0]       plane,
    input  logic [7:0]       ram_byte,
    output logic [BUS_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = (pend && (plane == 2'(g))) ? ram_byte
                                                             : rbuf[8*g +: 8];
    end
endmodule

// File: rtl/pktbuf_ptr_port.sv
module pktbuf_ptr_port import pbp_pkg::*; #(
    parameter int NUM_PAGES = 2,
    localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [3:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [BUS_W-1:0]  host_wdata,
    input  logic [PAGE_W-1:0] pkt_num,
    input  logic [PAGE_W-1:0] rx_head,
    output logic              host_busy,
    output logic              host_rvalid,
    output logic [BUS_W-1:0]  host_rdata
);
    localparam int RAM_AW = PAGE_W + OFF_W;

    seq_state_t q, d;

    logic [3:0]        cur_addr;
    logic [7:0]        cur_wbyte;
    logic              is_data;
    logic              is_lo;
    logic              is_hi;
    logic [1:0]        lane;
    logic [RAM_AW-1:0] ram_addr;
    logic [PTR_W-1:0]  ptr_stepped;
    logic [BUS_W-1:0]  merged;
    logic [7:0]        ram_rdata;
    logic              ram_we;
    logic              ram_re;

    // observation points for the checker
    logic              seq_run;
    logic              seq_mapped;
    logic [PTR_W-1:0]  ptr_cur;

    assign cur_addr  = q.base + {2'b00, q.idx};
    assign cur_wbyte = q.wdata[{q.idx, 3'b000} +: 8];
    assign is_data   = (cur_addr[3:2] == 2'b10);
    assign is_lo     = (cur_addr == ADR_PTR_LO);
    assign is_hi     = (cur_addr == ADR_PTR_HI);
    assign lane      = cur_addr[1:0];

    assign seq_run    = (q.st == ST_RUN);
    assign seq_mapped = is_data || is_lo || is_hi;
    assign ptr_cur    = q.ptr;

    pbp_addr_gen #(.PAGE_W(PAGE_W)) u_addr (
        .ptr      (q.ptr),
        .lane     (lane),
        .pkt_num  (pkt_num),
        .rx_head  (rx_head),
        .ram_addr (ram_addr),
        .ptr_next (ptr_stepped)
    );

    pbp_rd_merge u_merge (
        .rbuf     (q.rbuf),
        .pend     (q.pend),
        .plane    (q.plane),
        .ram_byte (ram_rdata),
        .merged   (merged)
    );

    pbp_byte_ram #(.ADDR_W(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (cur_wbyte),
        .rdata (ram_rdata)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        d.pend   = 1'b0;
        d.rbuf   = merged;
        ram_we   = 1'b0;
        ram_re   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (host_req) begin
                    d.st    = ST_RUN;
                    d.wr    = host_wr;
                    d.base  = host_addr;
                    d.last  = size_to_last(host_size);
                    d.idx   = 2'd0;
                    d.wdata = host_wdata;
                    d.rbuf  = '0;
                end
            end
            ST_RUN: begin
                if (q.wr) begin
                    if (is_lo) begin
                        d.ptr[7:0] = cur_wbyte;
                    end else if (is_hi) begin
                        d.ptr[15:8] = cur_wbyte;
                    end else if (is_data) begin
                        ram_we = 1'b1;
                        d.ptr  = ptr_stepped;
                    end
                end else begin
                    if (is_lo) begin
                        d.rbuf[{q.idx, 3'b000} +: 8] = q.ptr[7:0];
                    end else if (is_hi) begin
                        d.rbuf[{q.idx, 3'b000} +: 8] = q.ptr[15:8] & HI_RD_MASK;
                    end else if (is_data) begin
                        ram_re  = 1'b1;
                        d.pend  = 1'b1;
                        d.plane = q.idx;
                        d.ptr   = ptr_stepped;
                    end else begin
                        d.rbuf[{q.idx, 3'b000} +: 8] = 8'h00;
                    end
                end
                if (q.idx == q.last) begin
                    d.st = ST_DRAIN;
                end else begin
                    d.idx = q.idx + 2'd1;
                end
            end
            ST_DRAIN: begin
                d.st     = ST_IDLE;
                d.rvalid = 1'b1;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, wr: 1'b0, base: '0, last: '0, idx: '0,
                   wdata: '0, ptr: '0, rbuf: '0, pend: 1'b0, plane: '0,
                   rvalid: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign host_busy   = (q.st != ST_IDLE);
    assign host_rvalid = q.rvalid;
    assign host_rdata  = q.rbuf;
endmodule

// File: rtl/pktbuf_ptr_port_chk.sv
module pktbuf_ptr_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_busy,
    input logic        host_rvalid,
    input logic        seq_run,
    input logic        is_data,
    input logic        seq_mapped,
    input logic [15:0] ptr_cur
);
    // R8: completion pulse coincides with the port becoming free
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !host_busy);

    // R8: completion is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R8: an accepted request makes the port busy
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_busy) |=> host_busy);

    // R6: stepping advances the offset by one
    a_r6_step_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_run && is_data && ptr_cur[14])
        |=> ptr_cur[10:0] == 11'($past(ptr_cur[10:0]) + 11'd1));

    // R6: stepping keeps the flag field
    a_r6_step_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_run && is_data && ptr_cur[14]) |=> $stable(ptr_cur[15:11]));

    // R6: no stepping when the flag is clear
    a_r6_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_run && is_data && !ptr_cur[14]) |=> $stable(ptr_cur));

    // R9: bytes outside the window leave the pointer alone
    a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_run && !seq_mapped) |=> $stable(ptr_cur));
endmodule

bind pktbuf_ptr_port pktbuf_ptr_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_busy   (host_busy),
    .host_rvalid (host_rvalid),
    .seq_run     (seq_run),
    .is_data     (is_data),
    .seq_mapped  (seq_mapped),
    .ptr_cur     (ptr_cur)
);

// File: tb/pktbuf_ptr_port_bench.sv
module pktbuf_ptr_port_bench;
    localparam int NPG   = 2;
    localparam int PGB   = 2048;
    localparam int NB    = NPG * PGB;
    localparam int WDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [0:0]  pkt_num = '0;
    logic [0:0]  rx_head = '0;
    logic        host_busy;
    logic        host_rvalid;
    logic [31:0] host_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0]  mem_m [NB];
    bit          known_m [NB];
    logic [15:0] ptr_m = '0;

    always #4 clk = ~clk;

    pktbuf_ptr_port #(.NUM_PAGES(NPG)) u_pktbuf_ptr_port (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .pkt_num(pkt_num), .rx_head(rx_head), .host_busy(host_busy),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // drive one access, update the model, check latency and read data
    task automatic acc(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input string req);
        int n = nbytes(sz);
        logic [31:0] exp = '0;
        logic [31:0] kmask = '0;
        int lat = 0;
        for (int i = 0; i < n; i++) begin
            logic [3:0] ad = 4'(a + 4'(i));
            logic [7:0] b  = wd[8*i +: 8];
            if (ad == 4'd6) begin
                if (wr) ptr_m[7:0] = b;
                else begin exp[8*i +: 8] = ptr_m[7:0]; kmask[8*i +: 8] = 8'hFF; end
            end else if (ad == 4'd7) begin
                if (wr) ptr_m[15:8] = b;
                else begin exp[8*i +: 8] = ptr_m[15:8] & 8'hF7; kmask[8*i +: 8] = 8'hFF; end
            end else if (ad >= 4'd8 && ad <= 4'd11) begin
                int pg  = ptr_m[15] ? int'(rx_head) : int'(pkt_num);
                int off = (int'(ptr_m[10:0]) + int'(ad) - 8) % PGB;
                int ix  = pg * PGB + off;
                if (wr) begin
                    mem_m[ix] = b;
                    known_m[ix] = 1'b1;
                end else if (known_m[ix]) begin
                    exp[8*i +: 8] = mem_m[ix];
                    kmask[8*i +: 8] = 8'hFF;
                end
                if (ptr_m[14]) ptr_m[10:0] = ptr_m[10:0] + 11'd1;
            end else begin
                if (!wr) kmask[8*i +: 8] = 8'hFF;
            end
        end
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        while (!host_rvalid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == n + 1, "R8 latency", 32'(lat), 32'(n + 1));
        if (!wr) chk((host_rdata & kmask) == (exp & kmask), req,
                     host_rdata & kmask, exp & kmask);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) known_m[i] = 1'b0;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(host_busy == 1'b0, "R1 busy", 32'(host_busy), 32'd0);
        chk(host_rvalid == 1'b0, "R1 rvalid", 32'(host_rvalid), 32'd0);
        rst_n = 1'b1;
        acc(1'b0, 4'd6, 2'd1, 32'd0, "R1 pointer after reset");

        // R2: byte-lane writes of the pointer
        acc(1'b1, 4'd6, 2'd0, 32'h34, "R2");
        acc(1'b1, 4'd7, 2'd0, 32'h12, "R2");
        acc(1'b0, 4'd6, 2'd1, 32'd0, "R2 pointer both bytes");
        acc(1'b1, 4'd6, 2'd0, 32'hAB, "R2");
        acc(1'b0, 4'd6, 2'd1, 32'd0, "R2 high byte kept");

        // R3: high byte read masking
        acc(1'b1, 4'd7, 2'd0, 32'hFF, "R3");
        acc(1'b0, 4'd7, 2'd0, 32'd0, "R3 masked high byte");
        acc(1'b0, 4'd6, 2'd0, 32'd0, "R3 low byte unmasked");

        // R4: lane offsets
        pkt_num = 1'b0; rx_head = 1'b0;
        acc(1'b1, 4'd6, 2'd1, 32'h0010, "R4");
        acc(1'b1, 4'd8, 2'd2, 32'hDDCCBBAA, "R4");
        acc(1'b0, 4'd8, 2'd2, 32'd0, "R4 word readback");
        acc(1'b0, 4'd10, 2'd0, 32'd0, "R4 lane 2 byte");
        acc(1'b1, 4'd6, 2'd1, 32'h0012, "R4");
        acc(1'b0, 4'd8, 2'd0, 32'd0, "R4 shifted pointer");

        // R10: lane wrap at page end
        acc(1'b1, 4'd6, 2'd1, 32'h07FE, "R10");
        acc(1'b1, 4'd8, 2'd2, 32'h11223344, "R10");
        acc(1'b1, 4'd6, 2'd1, 32'h0000, "R10");
        acc(1'b0, 4'd8, 2'd2, 32'd0, "R10 wrapped bytes");

        // R6 / R7: stepping across a multi-byte access
        acc(1'b1, 4'd6, 2'd1, 32'h47FE, "R6");
        acc(1'b1, 4'd8, 2'd2, 32'h99887766, "R6");
        acc(1'b0, 4'd6, 2'd1, 32'd0, "R6 stepped pointer");
        acc(1'b1, 4'd6, 2'd1, 32'h47FE, "R7");
        acc(1'b0, 4'd8, 2'd2, 32'd0, "R7 sequential byte order");
        acc(1'b0, 4'd6, 2'd1, 32'd0, "R7 pointer after read");

        // R5: page selection
        pkt_num = 1'b0; rx_head = 1'b1;
        acc(1'b1, 4'd6, 2'd1, 32'h0020, "R5");
        acc(1'b1, 4'd8, 2'd0, 32'hA5, "R5");
        acc(1'b1, 4'd6, 2'd1, 32'h8020, "R5");
        acc(1'b1, 4'd8, 2'd0, 32'h5A, "R5");
        acc(1'b1, 4'd6, 2'd1, 32'h0020, "R5");
        acc(1'b0, 4'd8, 2'd0, 32'd0, "R5 packet-number page");
        pkt_num = 1'b1;
        acc(1'b0, 4'd8, 2'd0, 32'd0, "R5 queue-head page");

        // R9: unmapped addresses
        acc(1'b1, 4'd0, 2'd2, 32'hFFFFFFFF, "R9");
        acc(1'b1, 4'd12, 2'd2, 32'hFFFFFFFF, "R9");
        acc(1'b0, 4'd6, 2'd1, 32'd0, "R9 pointer untouched");
        acc(1'b0, 4'd12, 2'd2, 32'd0, "R9 reads zero");
        acc(1'b0, 4'd0, 2'd2, 32'd0, "R9 reads zero low");

        // R8: request while busy is ignored
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 4'd0; host_size = 2'd2;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 4'd6; host_size = 2'd0;
        host_wdata = 32'h55;
        @(negedge clk);
        @(negedge clk);
        host_req = 1'b0;
        begin
            int w = 0;
            while (!host_rvalid && w < 40) begin @(negedge clk); w++; end
            chk(w < 40, "R8 busy access completes", 32'(w), 32'd3);
        end
        acc(1'b0, 4'd6, 2'd1, 32'd0, "R8 request while busy ignored");

        // random mix
        for (int k = 0; k < 400; k++) begin
            bit          wr = 1'($urandom % 2);
            int          r  = $urandom % 10;
            logic [3:0]  a  = (r < 7) ? 4'(6 + $urandom % 6) : 4'($urandom % 16);
            logic [1:0]  sz = 2'($urandom % 4);
            logic [31:0] wd = $urandom;
            pkt_num = 1'($urandom % 2);
            rx_head = 1'($urandom % 2);
            acc(wr, a, sz, wd, "R7 random access");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule